// File: doc/BRIEF.md
# System Power Mode Controller

This block picks the operating mode of a small system. The modes are normal run, very-low-power run, very-low-power wait, normal stop, very-low-power stop and very low leakage stop. Software reaches the block through a byte-wide register bus that holds two registers. A permission register can be written only once after power-on and unlocks the low-power modes. A control register selects the run and stop variants, holds the wake-up-on-interrupt choice and flags stop attempts that were aborted.

A core asserts `sleep_req` together with `sleep_deep` to ask for a wait or stop entry. Any asserted `irq` pulls the system back out of a low-power mode. Where it returns depends on the wake-up bit and on the mode the low-power state was entered from. The block only reports the chosen mode through a one-hot status vector. Clock gating, regulator control and reset generation are handled by other blocks.

Top module: `lpm_ctrl`

## Requirements
- R1: After a power-on reset (`por_n` low), both registers read 0x00 and the status reports normal run (`mode_status` = 6'b000001).
- R2: The permission register keeps bit 5 (very-low-power allowed) and bit 1 (very low leakage allowed). All other bits read zero. Only the first write after a power-on reset takes effect, and later writes leave it unchanged.
- R3: The control register's run field is bits 6:5. Writing 2'b10 there in normal run enters very-low-power run only when permission bit 5 is set, and otherwise the mode stays. Writing 2'b00 in very-low-power run returns to normal run. The field reads 2'b10 in very-low-power run, very-low-power wait and very-low-power stop, and 2'b00 in every other mode.
- R4: A deep sleep request in normal run follows the stop field in bits 2:0. 3'b000 enters stop. 3'b010 enters very-low-power stop, but only with permission bit 5. 3'b100 enters very low leakage stop, but only with permission bit 1. From very-low-power run, 3'b000 or 3'b010 enters very-low-power stop, and 3'b100 needs bit 1. A shallow request moves very-low-power run to very-low-power wait and has no effect in normal run.
- R5: Bit 3 of the control register is set when a deep request is refused, or when a deep request arrives in the same cycle as `irq`. The next successful stop entry clears it.
- R6: With the wake bit (control bit 7) set, `irq` in very-low-power run, wait or stop returns the system to normal run.
- R7: With the wake bit clear, `irq` moves very-low-power wait and very-low-power stop to very-low-power run, and very-low-power run stays where it is.
- R8: A very-low-power stop entered directly from normal run always returns to normal run on `irq`.
- R9: `irq` in stop or in very low leakage stop returns the system to normal run.
- R10: Writes to the wake bit take effect only while the mode is normal run.
- R11: The stop field accepts only 3'b000, 3'b010 and 3'b100, and any other value written leaves it unchanged. Bit 4 reads zero.
- R12: A low pulse on `warm_rst_n` returns the mode to normal run and leaves both registers unchanged.
- R13: `mode_status` is one-hot. Bit 0 is run, 1 is very-low-power run, 2 is very-low-power wait, 3 is stop, 4 is very-low-power stop and 5 is very low leakage stop. It changes on the same clock edge that samples the causing request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| warm_rst_n | input | 1 | Warm reset, active low, resets only the mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select (0 permission, 1 control) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sleep_req | input | 1 | Single-cycle sleep request |
| sleep_deep | input | 1 | 1 asks for stop, 0 asks for wait |
| irq | input | 1 | Any active interrupt |
| mode_status | output | 6 | One-hot current mode |

## Verification
The bench targets the exit paths from very-low-power stop. A design that ignores how the stop was entered would drop back to very-low-power run even when stop was entered from normal run. A design that ignores the wake bit would take the wrong exit in the other cases. The bench writes the permission register twice and with reserved bits set. A lock that re-arms shows up as a changed readback, and a lock that leaks shows up as reserved bits read as ones. The bench also drives a deep request together with `irq`, tries a wake-bit write outside normal run and applies a warm reset. A controller that enters stop anyway, latches the wake bit or wipes the registers on warm reset is caught in the readback or the status.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      M_RUN  = 3'd0,
      M_VLPR = 3'd1,
      M_VLPW = 3'd2,
      M_STOP = 3'd3,
      M_VLPS = 3'd4,
      M_VLLS = 3'd5
   } lpm_mode_e;

   localparam int MODE_N = 6;
   localparam int REG_W  = 8;

   localparam logic [1:0] RUNSEL_NORM = 2'b00;
   localparam logic [1:0] RUNSEL_VLP  = 2'b10;

   localparam logic [2:0] STOPSEL_NORM = 3'b000;
   localparam logic [2:0] STOPSEL_VLP  = 3'b010;
   localparam logic [2:0] STOPSEL_LLS  = 3'b100;

   localparam int PERM_VLP_BIT = 5;
   localparam int PERM_LLS_BIT = 1;
   localparam int CTL_WAKE_BIT = 7;
   localparam int CTL_RUN_LSB  = 5;
   localparam int CTL_ABRT_BIT = 3;
   localparam int CTL_STOP_LSB = 0;

   function automatic logic stop_sel_legal(input logic [2:0] v);
      return (v == STOPSEL_NORM) || (v == STOPSEL_VLP) || (v == STOPSEL_LLS);
   endfunction

endpackage

// File: rtl/lpm_perm_reg.sv
module lpm_perm_reg #(
   parameter bit LLS_EN = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic wr_en,
   input  logic vlp_bit,
   input  logic lls_bit,
   output logic allow_vlp,
   output logic allow_lls
);

   logic locked_q;
   logic vlp_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         locked_q <= 1'b0;
         vlp_q    <= 1'b0;
      end else if (wr_en && !locked_q) begin
         locked_q <= 1'b1;
         vlp_q    <= vlp_bit;
      end
   end

   assign allow_vlp = vlp_q;

   generate
      if (LLS_EN) begin : g_lls
         logic lls_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
               lls_q <= 1'b0;
            else if (wr_en && !locked_q)
               lls_q <= lls_bit;
         end
         assign allow_lls = lls_q;
      end else begin : g_no_lls
         logic unused_lls;
         assign unused_lls = lls_bit;
         assign allow_lls  = 1'b0;
      end
   endgenerate

   // R2: once locked, a write changes neither permission
   p_write_once_r2: assert property (@(posedge clk) disable iff (!por_n)
      (locked_q && wr_en) |=> ($stable(allow_vlp) && $stable(allow_lls)));

endmodule

// File: rtl/lpm_ctl_reg.sv
module lpm_ctl_reg
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       wr_en,
   input  logic       wake_in,
   input  logic [2:0] stop_in,
   input  logic       in_run,
   input  logic       abort_set,
   input  logic       abort_clr,
   output logic       wake_q,
   output logic [2:0] stop_q,
   output logic       abort_q
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wake_q  <= 1'b0;
         stop_q  <= STOPSEL_NORM;
         abort_q <= 1'b0;
      end else begin
         if (wr_en && in_run)
            wake_q <= wake_in;
         if (wr_en && stop_sel_legal(stop_in))
            stop_q <= stop_in;
         if (abort_clr)
            abort_q <= 1'b0;
         else if (abort_set)
            abort_q <= 1'b1;
      end
   end

   // R10: outside normal run the wake bit holds across writes
   p_wake_gate_r10: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && !in_run) |=> $stable(wake_q));

   // R11: an illegal stop code leaves the field as it was
   p_stop_legal_r11: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && !stop_sel_legal(stop_in)) |=> $stable(stop_q));

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       warm_rst_n,
   input  logic       sleep_req,
   input  logic       sleep_deep,
   input  logic       irq,
   input  logic       wake,
   input  logic [2:0] stop_sel,
   input  logic       allow_vlp,
   input  logic       allow_lls,
   input  logic       run_wr,
   input  logic [1:0] run_sel,
   output lpm_mode_e  mode,
   output logic       abort_set,
   output logic       abort_clr
);

   lpm_mode_e mode_q, mode_d;
   logic      from_run_q, from_run_d;
   logic      deep_req;

   assign deep_req = sleep_req && sleep_deep;

   always_comb begin
      mode_d     = mode_q;
      from_run_d = from_run_q;
      abort_set  = 1'b0;
      abort_clr  = 1'b0;
      if (irq) begin
         unique case (mode_q)
            M_VLPR:         if (wake) mode_d = M_RUN;
            M_VLPW:         mode_d = wake ? M_RUN : M_VLPR;
            M_VLPS:         mode_d = (wake || from_run_q) ? M_RUN : M_VLPR;
            M_STOP, M_VLLS: mode_d = M_RUN;
            default:        mode_d = mode_q;
         endcase
         if (deep_req && (mode_q == M_RUN || mode_q == M_VLPR))
            abort_set = 1'b1;
      end else if (sleep_req) begin
         if (mode_q == M_RUN && sleep_deep) begin
            unique case (stop_sel)
               STOPSEL_NORM: begin
                  mode_d    = M_STOP;
                  abort_clr = 1'b1;
               end
               STOPSEL_VLP: begin
                  if (allow_vlp) begin
                     mode_d     = M_VLPS;
                     from_run_d = 1'b1;
                     abort_clr  = 1'b1;
                  end else begin
                     abort_set = 1'b1;
                  end
               end
               STOPSEL_LLS: begin
                  if (allow_lls) begin
                     mode_d    = M_VLLS;
                     abort_clr = 1'b1;
                  end else begin
                     abort_set = 1'b1;
                  end
               end
               default: abort_set = 1'b1;
            endcase
         end else if (mode_q == M_VLPR) begin
            if (!sleep_deep) begin
               mode_d = M_VLPW;
            end else if (stop_sel == STOPSEL_LLS) begin
               if (allow_lls) begin
                  mode_d    = M_VLLS;
                  abort_clr = 1'b1;
               end else begin
                  abort_set = 1'b1;
               end
            end else begin
               mode_d     = M_VLPS;
               from_run_d = 1'b0;
               abort_clr  = 1'b1;
            end
         end
      end else if (run_wr) begin
         if (mode_q == M_RUN && run_sel == RUNSEL_VLP && allow_vlp)
            mode_d = M_VLPR;
         else if (mode_q == M_VLPR && run_sel == RUNSEL_NORM)
            mode_d = M_RUN;
      end
   end

   always_ff @(posedge clk or negedge por_n or negedge warm_rst_n) begin
      if (!por_n || !warm_rst_n) begin
         mode_q     <= M_RUN;
         from_run_q <= 1'b0;
      end else begin
         mode_q     <= mode_d;
         from_run_q <= from_run_d;
      end
   end

   assign mode = mode_q;

   // R4: a refused low-leakage stop keeps normal run
   p_lls_refuse_r4: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      (mode_q == M_RUN && deep_req && !irq && stop_sel == STOPSEL_LLS && !allow_lls)
      |=> (mode_q == M_RUN));

   // R6: wake bit set sends every very-low-power mode back to run
   p_wake_exit_r6: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      (irq && wake && (mode_q == M_VLPR || mode_q == M_VLPW || mode_q == M_VLPS))
      |=> (mode_q == M_RUN));

   // R8: a stop entered straight from run leaves to run
   p_from_run_r8: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      (irq && mode_q == M_VLPS && from_run_q) |=> (mode_q == M_RUN));

   // R9: deep stops leave to run on any interrupt
   p_deep_exit_r9: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      (irq && (mode_q == M_STOP || mode_q == M_VLLS)) |=> (mode_q == M_RUN));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int ADDR_W    = 1,
   parameter int PERM_ADDR = 0,
   parameter int CTL_ADDR  = 1,
   parameter bit LLS_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              sleep_req,
   input  logic              sleep_deep,
   input  logic              irq,
   output logic [MODE_N-1:0] mode_status
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_W < 1) begin : g_bad_aw
         $error("lpm_ctrl: ADDR_W must be at least 1");
      end
      if (PERM_ADDR == CTL_ADDR) begin : g_bad_map
         $error("lpm_ctrl: register addresses collide");
      end
      if (PERM_ADDR >= ADDR_SPAN || CTL_ADDR >= ADDR_SPAN) begin : g_bad_range
         $error("lpm_ctrl: register address outside ADDR_W");
      end
   endgenerate

   logic      perm_wr, ctl_wr;
   logic      allow_vlp, allow_lls;
   logic      wake_q, abort_q, abort_set, abort_clr;
   logic [2:0] stop_q;
   lpm_mode_e mode;
   logic      in_vlp;
   logic [1:0] run_rd;
   logic [REG_W-1:0] perm_rd, ctl_rd;
   logic      unused_wbits;

   assign perm_wr = reg_we && (reg_addr == ADDR_W'(PERM_ADDR));
   assign ctl_wr  = reg_we && (reg_addr == ADDR_W'(CTL_ADDR));
   assign unused_wbits = ^{reg_wdata[4:3]};

   lpm_perm_reg #(.LLS_EN(LLS_EN)) u_perm (
      .clk       (clk),
      .por_n     (por_n),
      .wr_en     (perm_wr),
      .vlp_bit   (reg_wdata[PERM_VLP_BIT]),
      .lls_bit   (reg_wdata[PERM_LLS_BIT]),
      .allow_vlp (allow_vlp),
      .allow_lls (allow_lls)
   );

   lpm_ctl_reg u_ctl (
      .clk       (clk),
      .por_n     (por_n),
      .wr_en     (ctl_wr),
      .wake_in   (reg_wdata[CTL_WAKE_BIT]),
      .stop_in   (reg_wdata[CTL_STOP_LSB +: 3]),
      .in_run    (mode == M_RUN),
      .abort_set (abort_set),
      .abort_clr (abort_clr),
      .wake_q    (wake_q),
      .stop_q    (stop_q),
      .abort_q   (abort_q)
   );

   lpm_mode_fsm u_fsm (
      .clk        (clk),
      .por_n      (por_n),
      .warm_rst_n (warm_rst_n),
      .sleep_req  (sleep_req),
      .sleep_deep (sleep_deep),
      .irq        (irq),
      .wake       (wake_q),
      .stop_sel   (stop_q),
      .allow_vlp  (allow_vlp),
      .allow_lls  (allow_lls),
      .run_wr     (ctl_wr),
      .run_sel    (reg_wdata[CTL_RUN_LSB +: 2]),
      .mode       (mode),
      .abort_set  (abort_set),
      .abort_clr  (abort_clr)
   );

   assign in_vlp = (mode == M_VLPR) || (mode == M_VLPW) || (mode == M_VLPS);
   assign run_rd = in_vlp ? RUNSEL_VLP : RUNSEL_NORM;

   always_comb begin
      perm_rd = '0;
      perm_rd[PERM_VLP_BIT] = allow_vlp;
      perm_rd[PERM_LLS_BIT] = allow_lls;
      ctl_rd = '0;
      ctl_rd[CTL_WAKE_BIT]       = wake_q;
      ctl_rd[CTL_RUN_LSB +: 2]   = run_rd;
      ctl_rd[CTL_ABRT_BIT]       = abort_q;
      ctl_rd[CTL_STOP_LSB +: 3]  = stop_q;
   end

   assign reg_rdata = (reg_addr == ADDR_W'(CTL_ADDR)) ? ctl_rd : perm_rd;

   generate
      for (genvar i = 0; i < MODE_N; i++) begin : g_status
         assign mode_status[i] = (mode == lpm_mode_e'(i));
      end
   endgenerate

   // R5: a deep request colliding with an interrupt in run flags an abort
   p_abort_collide_r5: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      (mode == M_RUN && sleep_req && sleep_deep && irq) |=> ctl_rd[CTL_ABRT_BIT]);

   // R3: without permission a run-field write of 2'b10 keeps normal run
   p_vlpr_gate_r3: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
      (mode == M_RUN && ctl_wr && !sleep_req && !irq && !allow_vlp) |=> mode_status[0]);

endmodule

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/100ps
module lpm_ctrl_bench;

   localparam logic [5:0] S_RUN  = 6'b000001;
   localparam logic [5:0] S_VLPR = 6'b000010;
   localparam logic [5:0] S_VLPW = 6'b000100;
   localparam logic [5:0] S_STOP = 6'b001000;
   localparam logic [5:0] S_VLPS = 6'b010000;
   localparam logic [5:0] S_VLLS = 6'b100000;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       warm_rst_n = 1'b1;
   logic       reg_we = 1'b0;
   logic [0:0] reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       sleep_req = 1'b0;
   logic       sleep_deep = 1'b0;
   logic       irq = 1'b0;
   logic [5:0] mode_status;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [5:0] q_st[$];
   logic [7:0] q_rd[$];
   string      q_tag[$];

   always #2.5 clk = ~clk;

   lpm_ctrl u_lpm_ctrl (
      .clk         (clk),
      .por_n       (por_n),
      .warm_rst_n  (warm_rst_n),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .sleep_req   (sleep_req),
      .sleep_deep  (sleep_deep),
      .irq         (irq),
      .mode_status (mode_status)
   );

   // driver: one cycle of stimulus, expected post-edge values queued
   task automatic step(input logic we, input logic adr, input logic [7:0] wd,
                       input logic slp, input logic dp, input logic iq,
                       input logic [5:0] exp_st, input logic [7:0] exp_rd,
                       input string tag);
      @(negedge clk);
      reg_we = we; reg_addr = adr; reg_wdata = wd;
      sleep_req = slp; sleep_deep = dp; irq = iq;
      q_st.push_back(exp_st);
      q_rd.push_back(exp_rd);
      q_tag.push_back(tag);
      @(posedge clk);
   endtask

   task automatic idle_inputs();
      @(negedge clk);
      reg_we = 1'b0; sleep_req = 1'b0; sleep_deep = 1'b0; irq = 1'b0;
   endtask

   // monitor: compare just after each edge, before the next drive
   always @(posedge clk) begin
      #1;
      if (q_st.size() != 0) begin
         logic [5:0] est;
         logic [7:0] erd;
         string      t;
         est = q_st.pop_front();
         erd = q_rd.pop_front();
         t   = q_tag.pop_front();
         n_vec++;
         if (mode_status !== est || reg_rdata !== erd) begin
            n_bad++;
            $display("FAIL %s: status=%b rdata=%h expected status=%b rdata=%h",
                     t, mode_status, reg_rdata, est, erd);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) por_n = 1'b1;

      // R1 reset state
      step(0, 0, 8'h00, 0, 0, 0, S_RUN, 8'h00, "R1 perm after por");
      step(0, 1, 8'h00, 0, 0, 0, S_RUN, 8'h00, "R1 ctl after por");

      // R4 plain stop, R9 exit
      step(0, 1, 8'h00, 1, 1, 0, S_STOP, 8'h00, "R4 stop from run");
      step(0, 1, 8'h00, 0, 0, 1, S_RUN,  8'h00, "R9 irq leaves stop");
      step(0, 1, 8'h00, 1, 0, 0, S_RUN,  8'h00, "R4 shallow in run ignored");

      // R5 refusal without permission
      step(1, 1, 8'h02, 0, 0, 0, S_RUN, 8'h02, "R11 stop field vlp");
      step(0, 1, 8'h00, 1, 1, 0, S_RUN, 8'h0A, "R5 refused vlp stop");
      step(1, 1, 8'h42, 0, 0, 0, S_RUN, 8'h0A, "R3 vlpr refused");

      // R2 write-once
      step(1, 0, 8'hFF, 0, 0, 0, S_RUN, 8'h22, "R2 first write reserved zero");
      step(1, 0, 8'h00, 0, 0, 0, S_RUN, 8'h22, "R2 second write ignored");

      // R8 vlps from run
      step(0, 1, 8'h00, 1, 1, 0, S_VLPS, 8'h42, "R4 vlps from run clears abort");
      step(0, 1, 8'h00, 0, 0, 1, S_RUN,  8'h02, "R8 from-run exit");

      // R3 / R7 paths with wake clear
      step(1, 1, 8'h42, 0, 0, 0, S_VLPR, 8'h42, "R3 enter vlpr");
      step(0, 1, 8'h00, 0, 0, 1, S_VLPR, 8'h42, "R7 vlpr stays");
      step(0, 1, 8'h00, 1, 0, 0, S_VLPW, 8'h42, "R4 shallow to vlpw");
      step(0, 1, 8'h00, 0, 0, 1, S_VLPR, 8'h42, "R7 vlpw to vlpr");
      step(0, 1, 8'h00, 1, 1, 0, S_VLPS, 8'h42, "R4 vlps from vlpr");
      step(0, 1, 8'h00, 0, 0, 1, S_VLPR, 8'h42, "R7 vlps to vlpr");
      step(1, 1, 8'hC2, 0, 0, 0, S_VLPR, 8'h42, "R10 wake write outside run");
      step(1, 1, 8'h02, 0, 0, 0, S_RUN,  8'h02, "R3 back to run");

      // R6 wake set
      step(1, 1, 8'h82, 0, 0, 0, S_RUN,  8'h82, "R10 wake write in run");
      step(1, 1, 8'hC2, 0, 0, 0, S_VLPR, 8'hC2, "R3 vlpr with wake");
      step(0, 1, 8'h00, 0, 0, 1, S_RUN,  8'h82, "R6 vlpr wakes to run");
      step(1, 1, 8'hC2, 0, 0, 0, S_VLPR, 8'hC2, "R3 vlpr again");
      step(0, 1, 8'h00, 1, 1, 0, S_VLPS, 8'hC2, "R4 vlps from vlpr wake");
      step(0, 1, 8'h00, 0, 0, 1, S_RUN,  8'h82, "R6 vlps wakes to run");

      // low leakage stop, collision, R9
      step(1, 1, 8'h84, 0, 0, 0, S_RUN,  8'h84, "R11 stop field lls");
      step(0, 1, 8'h00, 1, 1, 0, S_VLLS, 8'h84, "R4 lls entry");
      step(0, 1, 8'h00, 0, 0, 1, S_RUN,  8'h84, "R9 irq leaves lls");
      step(0, 1, 8'h00, 1, 1, 1, S_RUN,  8'h8C, "R5 collision aborts");
      step(0, 1, 8'h00, 1, 1, 0, S_VLLS, 8'h84, "R5 entry clears abort");
      idle_inputs();

      // R12 warm reset
      warm_rst_n = 1'b0;
      step(0, 1, 8'h00, 0, 0, 0, S_RUN, 8'h84, "R12 warm keeps ctl");
      @(negedge clk) warm_rst_n = 1'b1;
      step(0, 0, 8'h00, 0, 0, 0, S_RUN, 8'h22, "R12 warm keeps perm");
      idle_inputs();

      // second power-on: lock re-armed, lls refused
      por_n = 1'b0;
      @(negedge clk) por_n = 1'b1;
      step(0, 1, 8'h00, 0, 0, 0, S_RUN, 8'h00, "R1 ctl after second por");
      step(1, 0, 8'h20, 0, 0, 0, S_RUN, 8'h20, "R2 lock re-armed");
      step(1, 1, 8'h04, 0, 0, 0, S_RUN, 8'h04, "R11 lls code stored");
      step(0, 1, 8'h00, 1, 1, 0, S_RUN, 8'h0C, "R4 lls refused");
      step(1, 1, 8'h17, 0, 0, 0, S_RUN, 8'h0C, "R11 illegal stop code");
      step(0, 1, 8'h00, 0, 0, 0, S_RUN, 8'h0C, "R13 status holds run");
      idle_inputs();
      repeat (3) @(posedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule